// File: doc/BRIEF.md
# Retentive Up/Down Event Counter

This block is a signed 16-bit event counter with separate count-up and count-down request lines. The requests are not counted on every clock: they are sampled only on cycles where `scan_en` is high. A request counts once when it reads true at a scan after it read false at the previous scan. A request held true over many scans therefore moves the count by exactly one step.

The accumulator wraps in both directions and leaves a sticky flag behind each time. A pair of enable flags mirrors the most recent sampled level of each request. A done flag compares the accumulator live against a preset value supplied on an input. The accumulator and these flags keep their values indefinitely. Only the synchronous `clear_cmd` command clears them; the hardware reset `rst_n` is used at power-up only. All flags are packed into one 16-bit status word that is presented beside the accumulator.

Top module: `updn_event_counter`

## Requirements
- R1: At a scan where `up_req` is 1 and it was 0 at the previous scan (or no scan has occurred since reset or hardware reset), the accumulator increases by one at that clock edge. A request held at 1 over later scans adds nothing more.
- R2: At a scan where `dn_req` is 1 and it was 0 at the previous scan, the accumulator decreases by one at that clock edge. A held request subtracts nothing more.
- R3: An increment from 0x7FFF (+32767) gives 0x8000 (-32768) and sets the overflow flag, status bit 12. A decrement from 0x8000 gives 0x7FFF and sets the underflow flag, status bit 11.
- R4: The overflow flag clears on any net decrement step. The underflow flag clears on any net increment step. Each flag otherwise stays set until a clear command.
- R5: Status bit 13 (done) is 1 exactly when the accumulator, read as signed, is greater than or equal to the signed `preset` input. It follows a change of `preset` without waiting for a clock edge.
- R6: Status bit 15 (up enable) and bit 14 (down enable) take the level of `up_req` and `dn_req` at each scan. They hold that value between scans, and a clear command sets them to 0.
- R7: On cycles with neither `scan_en` nor `clear_cmd`, the request lines are ignored and the accumulator and all flags hold their values.
- R8: `clear_cmd` sets the accumulator to 0 and clears bits 15, 14, 12 and 11 at the next edge. It takes priority over a scan in the same cycle, but that scan still records the request levels used to detect later edges. `preset` is not affected.
- R9: When both requests rise at the same scan, the accumulator and the overflow and underflow flags are unchanged, and both enable flags are set.
- R10: Status bits 10 down to 0 always read 0.
- R11: After `rst_n` is released, the accumulator is 0, bits 15, 14, 12 and 11 are 0, and both requests count as previously sampled false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scan_en | input | 1 | Sample strobe for the request lines |
| up_req | input | 1 | Count-up request level |
| dn_req | input | 1 | Count-down request level |
| clear_cmd | input | 1 | Synchronous clear of the accumulator and flags |
| preset | input | 16 | Signed compare value for the done flag |
| accum | output | 16 | Signed accumulator |
| ctrl_word | output | 16 | Packed status: 15 up enable, 14 down enable, 13 done, 12 overflow, 11 underflow |

## Verification
The counting step and the clear command can fall in the same cycle, and so can an up edge and a down edge. The bench drives a scan with a rising request together with `clear_cmd`. It then expects a zero accumulator and no count at the following scan. It also drives both requests rising at one scan and expects the accumulator and wrap flags to stay as they were while both enables set. Both collisions are also produced at random, and every cycle is compared against a bench model of the requirements.

// File: rtl/uc_pkg.sv
package uc_pkg;
    localparam int WORD_W   = 16;
    localparam int BIT_UEN  = 15;
    localparam int BIT_DEN  = 14;
    localparam int BIT_DONE = 13;
    localparam int BIT_OVF  = 12;
    localparam int BIT_UNF  = 11;
    localparam int CH_UP    = 0;
    localparam int CH_DN    = 1;
    localparam int N_CH     = 2;

    typedef struct packed {
        logic up_en;
        logic dn_en;
        logic ovf;
        logic unf;
    } uc_flags_t;
endpackage

// File: rtl/uc_edge_sampler.sv
module uc_edge_sampler #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic [CH-1:0] req,
    output logic [CH-1:0] rise
);
    typedef struct packed {
        logic [CH-1:0] hist;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (scan_en) smp_d.hist = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    for (genvar i = 0; i < CH; i++) begin : g_ch
        assign rise[i] = scan_en & req[i] & ~smp_q.hist[i];

        // R1
        rise_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/uc_step_unit.sv
module uc_step_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_q,
    input  logic         up_edge,
    input  logic         dn_edge,
    output logic [W-1:0] acc_step,
    output logic         net_up,
    output logic         net_dn,
    output logic         wrap_hi,
    output logic         wrap_lo
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        net_up   = up_edge & ~dn_edge;
        net_dn   = dn_edge & ~up_edge;
        wrap_hi  = net_up & (acc_q == MAX_POS);
        wrap_lo  = net_dn & (acc_q == MIN_NEG);
        acc_step = acc_q;
        if (net_up)      acc_step = acc_q + ONE;
        else if (net_dn) acc_step = acc_q - ONE;
    end
endmodule

// File: rtl/uc_status.sv
module uc_status
    import uc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear_cmd,
    input  logic      scan_en,
    input  logic      up_lvl,
    input  logic      dn_lvl,
    input  logic      net_up,
    input  logic      net_dn,
    input  logic      wrap_hi,
    input  logic      wrap_lo,
    output uc_flags_t flags
);
    uc_flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (clear_cmd) begin
            flg_d = '0;
        end else begin
            if (scan_en) begin
                flg_d.up_en = up_lvl;
                flg_d.dn_en = dn_lvl;
            end
            if (net_up) begin
                flg_d.unf = 1'b0;
                if (wrap_hi) flg_d.ovf = 1'b1;
            end
            if (net_dn) begin
                flg_d.ovf = 1'b0;
                if (wrap_lo) flg_d.unf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;

    // R4
    ovf_unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flg_q.ovf && flg_q.unf));

    // R6
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !clear_cmd) |=> ($stable(flg_q.up_en) && $stable(flg_q.dn_en)));
endmodule

// File: rtl/updn_event_counter.sv
module updn_event_counter
    import uc_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             clear_cmd,
    input  logic [ACC_W-1:0] preset,
    output logic [ACC_W-1:0] accum,
    output logic [WORD_W-1:0] ctrl_word
);
    localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_NEG = {1'b1, {(ACC_W-1){1'b0}}};

    logic [N_CH-1:0]  req_vec;
    logic [N_CH-1:0]  rise_vec;
    logic [ACC_W-1:0] acc_step;
    logic             net_up, net_dn, wrap_hi, wrap_lo;
    logic             done;
    uc_flags_t        flags;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } core_t;

    core_t core_d, core_q;

    assign req_vec[CH_UP] = up_req;
    assign req_vec[CH_DN] = dn_req;

    uc_edge_sampler #(.CH(N_CH)) sampler_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .req     (req_vec),
        .rise    (rise_vec)
    );

    uc_step_unit #(.W(ACC_W)) step_i (
        .acc_q    (core_q.acc),
        .up_edge  (rise_vec[CH_UP]),
        .dn_edge  (rise_vec[CH_DN]),
        .acc_step (acc_step),
        .net_up   (net_up),
        .net_dn   (net_dn),
        .wrap_hi  (wrap_hi),
        .wrap_lo  (wrap_lo)
    );

    uc_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_cmd (clear_cmd),
        .scan_en   (scan_en),
        .up_lvl    (up_req),
        .dn_lvl    (dn_req),
        .net_up    (net_up),
        .net_dn    (net_dn),
        .wrap_hi   (wrap_hi),
        .wrap_lo   (wrap_lo),
        .flags     (flags)
    );

    always_comb begin
        core_d = core_q;
        if (clear_cmd) core_d.acc = '0;
        else           core_d.acc = acc_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign done  = $signed(core_q.acc) >= $signed(preset);
    assign accum = core_q.acc;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_UEN]  = flags.up_en;
        ctrl_word[BIT_DEN]  = flags.dn_en;
        ctrl_word[BIT_DONE] = done;
        ctrl_word[BIT_OVF]  = flags.ovf;
        ctrl_word[BIT_UNF]  = flags.unf;
    end

    // R7
    accum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !clear_cmd) |=> $stable(accum));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> (accum == '0 && !ctrl_word[BIT_UEN] && !ctrl_word[BIT_DEN]
                       && !ctrl_word[BIT_OVF] && !ctrl_word[BIT_UNF]));

    // R3
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_cmd && rise_vec[CH_UP] && !rise_vec[CH_DN] && accum == MAX_POS)
        |=> (accum == MIN_NEG && ctrl_word[BIT_OVF]));

    // R3
    unf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_cmd && rise_vec[CH_DN] && !rise_vec[CH_UP] && accum == MIN_NEG)
        |=> (accum == MAX_POS && ctrl_word[BIT_UNF]));

    // R9
    both_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_cmd && rise_vec[CH_UP] && rise_vec[CH_DN]) |=> $stable(accum));
endmodule

// File: tb/updn_event_counter_tb_top.sv
module updn_event_counter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_en = 1'b0, up_req = 1'b0, dn_req = 1'b0, clear_cmd = 1'b0;
    logic [15:0] preset = 16'd5;
    logic [15:0] accum;
    logic [15:0] ctrl_word;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_acc = '0;
    bit m_ov = 0, m_un = 0, m_ue = 0, m_de = 0, m_hu = 0, m_hd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_event_counter dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .up_req(up_req),
        .dn_req(dn_req), .clear_cmd(clear_cmd), .preset(preset),
        .accum(accum), .ctrl_word(ctrl_word)
    );

    function automatic logic [15:0] exp_ctrl();
        logic d;
        d = $signed(m_acc) >= $signed(preset);
        return {m_ue, m_de, d, m_ov, m_un, 11'b0};
    endfunction

    task automatic model_step(bit s, bit u, bit dn, bit c);
        bit ru, rd;
        ru = s && u && !m_hu;
        rd = s && dn && !m_hd;
        if (c) begin
            m_acc = '0; m_ov = 0; m_un = 0; m_ue = 0; m_de = 0;
        end else begin
            if (s) begin m_ue = u; m_de = dn; end
            if (ru && !rd) begin
                m_un = 0;
                if (m_acc == 16'h7FFF) m_ov = 1;
                m_acc = m_acc + 16'd1;
            end else if (rd && !ru) begin
                m_ov = 0;
                if (m_acc == 16'h8000) m_un = 1;
                m_acc = m_acc - 16'd1;
            end
        end
        if (s) begin m_hu = u; m_hd = dn; end
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit s, bit u, bit dn, bit c);
        @(negedge clk);
        scan_en = s; up_req = u; dn_req = dn; clear_cmd = c;
        @(posedge clk);
        model_step(s, u, dn, c);
        #1;
    endtask

    task automatic chk_all(string tag);
        chk({tag, " accum"}, accum, m_acc);
        chk({tag, " ctrl"}, ctrl_word, exp_ctrl());
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R11 hardware reset state
        chk("R11 reset accum", accum, 16'h0000);
        chk("R11 reset ctrl", ctrl_word, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        // R1 single edge, then held request
        cyc(1, 1, 0, 0); chk_all("R1 first edge");
        chk("R1 accum one", accum, 16'd1);
        cyc(1, 1, 0, 0); chk("R1 held no count", accum, 16'd1);
        cyc(1, 0, 0, 0); cyc(1, 1, 0, 0); chk("R1 second edge", accum, 16'd2);

        // R7 toggling without scan is ignored
        cyc(0, 0, 1, 0); cyc(0, 1, 0, 0); cyc(0, 0, 1, 0);
        chk("R7 no scan accum", accum, 16'd2);
        chk("R7 no scan ctrl", ctrl_word, exp_ctrl());

        // R6 enable follows sampled level
        chk("R6 up enable bit15", {15'b0, ctrl_word[15]}, 16'd1);
        cyc(1, 0, 0, 0); chk("R6 up enable drops", {15'b0, ctrl_word[15]}, 16'd0);

        // R2 down counting
        cyc(1, 0, 1, 0); chk("R2 down edge", accum, 16'd1);
        chk("R6 down enable bit14", {15'b0, ctrl_word[14]}, 16'd1);
        cyc(1, 0, 1, 0); chk("R2 held no count", accum, 16'd1);
        cyc(1, 0, 0, 0); cyc(1, 0, 1, 0); cyc(1, 0, 0, 0); cyc(1, 0, 1, 0);
        chk("R2 below zero", accum, 16'hFFFF);

        // R5 live compare against preset
        preset = 16'hFFFF; #1; chk("R5 equal done", {15'b0, ctrl_word[13]}, 16'd1);
        preset = 16'h0000; #1; chk("R5 below preset", {15'b0, ctrl_word[13]}, 16'd0);
        preset = 16'h8000; #1; chk("R5 signed compare", {15'b0, ctrl_word[13]}, 16'd1);

        // R9 simultaneous edges
        cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 0);
        chk("R9 both edges accum", accum, 16'hFFFF);
        chk("R9 both enables", {14'b0, ctrl_word[15:14]}, 16'd3);
        chk_all("R9 full");

        // R8 clear with concurrent scan edge
        cyc(1, 0, 0, 0); cyc(1, 1, 0, 0); cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 1);
        chk("R8 clear wins accum", accum, 16'h0000);
        chk("R8 clear flags", ctrl_word & 16'hD800, 16'h0000);
        chk("R8 preset kept", preset, 16'h8000);
        cyc(1, 1, 0, 0); chk("R8 history kept no count", accum, 16'h0000);

        // R3 climb to the positive limit
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 32767; i++) begin
            cyc(1, 1, 0, 0);
            cyc(1, 0, 0, 0);
        end
        chk("R3 at max", accum, 16'h7FFF);
        cyc(1, 1, 0, 0);
        chk("R3 wrap to min", accum, 16'h8000);
        chk("R3 overflow bit12", {15'b0, ctrl_word[12]}, 16'd1);
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        chk("R4 overflow sticky", {15'b0, ctrl_word[12]}, 16'd1);
        cyc(1, 0, 1, 0);
        chk("R3 down wrap to max", accum, 16'h7FFF);
        chk("R3 underflow bit11", {15'b0, ctrl_word[11]}, 16'd1);
        chk("R4 down clears overflow", {15'b0, ctrl_word[12]}, 16'd0);
        cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);
        chk("R4 up clears underflow", {15'b0, ctrl_word[11]}, 16'd0);
        chk_all("R4 full");
        cyc(0, 0, 0, 1);
        chk("R8 clear drops overflow", ctrl_word & 16'hD800, 16'h0000);
        chk("R10 spare bits", ctrl_word & 16'h07FF, 16'h0000);

        // Random mix, every cycle compared with the model (R1 R2 R6 R7 R8 R9 R10)
        for (int n = 0; n < 4000; n++) begin
            bit s, u, dn, c;
            s  = ($urandom % 2) == 0;
            u  = ($urandom % 3) == 0;
            dn = ($urandom % 3) == 0;
            c  = ($urandom % 40) == 0;
            if (($urandom % 50) == 0) preset = 16'($signed($urandom % 21) - 10);
            cyc(s, u, dn, c);
            chk_all("R1R2 random");
            chk("R10 random spare", ctrl_word & 16'h07FF, 16'h0000);
        end

        finish_run();
    end
endmodule